// File: doc/BRIEF.md
# DMA Transaction Cookie Tracker

This block numbers the transactions of one DMA channel. Each accepted submit strobe takes the next identifier (a cookie) from a counter. The counter runs over the strictly positive values of a signed `COOKIE_W`-bit word and then starts again at 1. The block also holds the most recent cookie that was issued and the most recent cookie that was retired. From that pair, together with the pause input and a record of the last completion that carried an error, it classifies any cookie placed on the query port.

The query path is combinational and reads only registered state. Software can therefore sample the status together with the issued/retired pair and then classify further cookies itself without asking again. A submit that arrives while the channel is paused is refused. The refusal is reported as a negative cookie, and a flag that follows the sign bit of the returned value goes high with it.

Because the counter wraps, the retired value can be larger than the issued value. In that case the completion test inverts its window: a plain magnitude compare would give wrong answers.

Top module: `cookie_tracker`

## Requirements
- R1: After a synchronous reset, `last_used_o` and `last_done_o` are 0, `new_valid_o` is 0, and the first accepted submit returns cookie 1.
- R2: A submit with `pause_i` low is accepted. One cycle later, `new_valid_o` pulses, `new_cookie_o` holds the next cookie, and `last_used_o` equals that same cookie.
- R3: The cookie that follows the maximum positive value 2^(COOKIE_W-1)-1 is 1. Zero and negative values are never issued.
- R4: A submit while `pause_i` is high is refused. One cycle later, `new_valid_o` pulses, `new_cookie_o` is all ones (-1) and `submit_err_o` is 1. `last_used_o` does not change. `submit_err_o` is 1 exactly when `new_cookie_o` is negative.
- R5: A completion strobe sets `last_done_o` to `done_cookie_i` one cycle later. Completions must name a cookie that is currently in progress, which means they arrive in issue order.
- R6: `query_status_o` encodes 0 = success, 1 = in progress, 2 = paused, 3 = error. It follows `query_cookie_i` and `pause_i` in the same cycle.
- R7: When `last_done_o <= last_used_o` (signed compare), a query is complete if it is `<= last_done_o` or `> last_used_o`.
- R8: When `last_done_o > last_used_o` (wrapped), a query is complete only if it is `<= last_done_o` and `> last_used_o`.
- R9: A query that is not complete reports paused (2) while `pause_i` is high and in progress (1) otherwise.
- R10: A completion with `done_err_i` high records its cookie. A complete query equal to the recorded cookie reports error (3). Any other complete query reports success (0). The record is dropped when that cookie value is issued again, and it is replaced by a later errored completion.
- R11: A submit and a completion in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| submit_i | input | 1 | Request a cookie for a new descriptor |
| pause_i | input | 1 | Channel paused: refuses submits, marks open queries paused |
| done_i | input | 1 | Completion strobe |
| done_cookie_i | input | COOKIE_W | Cookie being retired |
| done_err_i | input | 1 | The retired transaction failed |
| query_cookie_i | input | COOKIE_W | Cookie to classify |
| new_cookie_o | output | COOKIE_W | Cookie returned for the last submit (-1 if refused) |
| new_valid_o | output | 1 | One-cycle pulse: `new_cookie_o` is fresh |
| submit_err_o | output | 1 | Returned cookie is negative |
| query_status_o | output | 2 | Status of `query_cookie_i` |
| last_done_o | output | COOKIE_W | Last retired cookie |
| last_used_o | output | COOKIE_W | Last issued cookie |

## Verification
The submit results and `last_done_o`/`last_used_o` are due one register stage after the strobe. The bench drives strobes at the falling edge and compares those outputs 1 ns after the next rising edge, after updating its arithmetic model for that edge. The query status carries no register. After each edge, the bench sweeps all 2^COOKIE_W query values, once with pause low and once with pause high, in short steps that end well before the following edge. With a 4-bit cookie, several hundred cycles of pseudo-random submits, refusals and in-order completions wrap the counter many times, so both compare windows are swept exhaustively.

// File: rtl/cookie_trk_pkg.sv
package cookie_trk_pkg;
  typedef enum logic [1:0] {
    ST_SUCCESS = 2'd0,
    ST_OPEN    = 2'd1,
    ST_HELD    = 2'd2,
    ST_FAULT   = 2'd3
  } cookie_stat_e;
endpackage

// File: rtl/cookie_issue.sv
module cookie_issue #(
  parameter int COOKIE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                submit_i,
  input  logic                hold_i,
  output logic                fire_o,
  output logic [COOKIE_W-1:0] next_o,
  output logic [COOKIE_W-1:0] used_o,
  output logic [COOKIE_W-1:0] ret_o,
  output logic                ret_valid_o
);
  localparam logic [COOKIE_W-1:0] CMAX   = {1'b0, {(COOKIE_W-1){1'b1}}};
  localparam logic [COOKIE_W-1:0] CMIN   = {{(COOKIE_W-1){1'b0}}, 1'b1};
  localparam logic [COOKIE_W-1:0] REFUSE = {COOKIE_W{1'b1}};

  logic [COOKIE_W-1:0] used_q, ret_q;
  logic                rv_q;

  assign next_o = (used_q == CMAX) ? CMIN : used_q + CMIN;
  assign fire_o = submit_i & ~hold_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      ret_q  <= '0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= submit_i;
      if (submit_i) begin
        if (hold_i) begin
          ret_q <= REFUSE;
        end else begin
          used_q <= next_o;
          ret_q  <= next_o;
        end
      end
    end
  end

  assign used_o      = used_q;
  assign ret_o       = ret_q;
  assign ret_valid_o = rv_q;
endmodule

// File: rtl/cookie_retire.sv
module cookie_retire #(
  parameter int COOKIE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done_i,
  input  logic [COOKIE_W-1:0] done_cookie_i,
  input  logic                done_err_i,
  input  logic                fire_i,
  input  logic [COOKIE_W-1:0] issue_val_i,
  output logic [COOKIE_W-1:0] done_o,
  output logic [COOKIE_W-1:0] fault_cookie_o,
  output logic                fault_valid_o
);
  logic [COOKIE_W-1:0] done_q, fc_q;
  logic                fv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      fc_q   <= '0;
      fv_q   <= 1'b0;
    end else begin
      if (done_i) done_q <= done_cookie_i;
      if (done_i && done_err_i) begin
        fc_q <= done_cookie_i;
        fv_q <= 1'b1;
      end else if (fire_i && fv_q && issue_val_i == fc_q) begin
        fv_q <= 1'b0;
      end
    end
  end

  assign done_o         = done_q;
  assign fault_cookie_o = fc_q;
  assign fault_valid_o  = fv_q;
endmodule

// File: rtl/cookie_judge.sv
module cookie_judge
  import cookie_trk_pkg::*;
#(
  parameter int COOKIE_W = 32
) (
  input  logic [COOKIE_W-1:0] query_i,
  input  logic [COOKIE_W-1:0] done_i,
  input  logic [COOKIE_W-1:0] used_i,
  input  logic [COOKIE_W-1:0] fault_cookie_i,
  input  logic                fault_valid_i,
  input  logic                hold_i,
  output cookie_stat_e        stat_o
);
  logic signed [COOKIE_W-1:0] q_s, d_s, u_s;
  logic at_or_below_done, above_used, wrapped, finished;

  assign q_s = query_i;
  assign d_s = done_i;
  assign u_s = used_i;

  assign at_or_below_done = (q_s <= d_s);
  assign above_used       = (q_s > u_s);
  assign wrapped          = (d_s > u_s);
  assign finished = wrapped ? (at_or_below_done && above_used)
                            : (at_or_below_done || above_used);

  always_comb begin
    if (finished)
      stat_o = (fault_valid_i && query_i == fault_cookie_i) ? ST_FAULT : ST_SUCCESS;
    else
      stat_o = hold_i ? ST_HELD : ST_OPEN;
  end
endmodule

// File: rtl/cookie_tracker.sv
module cookie_tracker
  import cookie_trk_pkg::*;
#(
  parameter int COOKIE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                submit_i,
  input  logic                pause_i,
  input  logic                done_i,
  input  logic [COOKIE_W-1:0] done_cookie_i,
  input  logic                done_err_i,
  input  logic [COOKIE_W-1:0] query_cookie_i,
  output logic [COOKIE_W-1:0] new_cookie_o,
  output logic                new_valid_o,
  output logic                submit_err_o,
  output logic [1:0]          query_status_o,
  output logic [COOKIE_W-1:0] last_done_o,
  output logic [COOKIE_W-1:0] last_used_o
);
  logic                fire;
  logic [COOKIE_W-1:0] next_c, used_c, done_c, fault_c;
  logic                fault_v;
  cookie_stat_e        stat;

  cookie_issue #(.COOKIE_W(COOKIE_W)) issue_u (
    .clk(clk), .rst(rst), .submit_i(submit_i), .hold_i(pause_i),
    .fire_o(fire), .next_o(next_c), .used_o(used_c),
    .ret_o(new_cookie_o), .ret_valid_o(new_valid_o)
  );

  cookie_retire #(.COOKIE_W(COOKIE_W)) retire_u (
    .clk(clk), .rst(rst), .done_i(done_i), .done_cookie_i(done_cookie_i),
    .done_err_i(done_err_i), .fire_i(fire), .issue_val_i(next_c),
    .done_o(done_c), .fault_cookie_o(fault_c), .fault_valid_o(fault_v)
  );

  cookie_judge #(.COOKIE_W(COOKIE_W)) judge_u (
    .query_i(query_cookie_i), .done_i(done_c), .used_i(used_c),
    .fault_cookie_i(fault_c), .fault_valid_i(fault_v), .hold_i(pause_i),
    .stat_o(stat)
  );

  assign submit_err_o   = new_cookie_o[COOKIE_W-1];
  assign query_status_o = stat;
  assign last_done_o    = done_c;
  assign last_used_o    = used_c;
endmodule

// File: rtl/cookie_tracker_chk.sv
module cookie_tracker_chk #(
  parameter int COOKIE_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                submit_i,
  input logic                pause_i,
  input logic                done_i,
  input logic [COOKIE_W-1:0] done_cookie_i,
  input logic [COOKIE_W-1:0] new_cookie_o,
  input logic                new_valid_o,
  input logic                submit_err_o,
  input logic [1:0]          query_status_o,
  input logic [COOKIE_W-1:0] last_done_o,
  input logic [COOKIE_W-1:0] last_used_o
);
  localparam logic [COOKIE_W-1:0] TOP = {1'b0, {(COOKIE_W-1){1'b1}}};

  function automatic logic retired(input logic [COOKIE_W-1:0] c,
                                   input logic [COOKIE_W-1:0] d,
                                   input logic [COOKIE_W-1:0] u);
    if ($signed(d) > $signed(u))
      return ($signed(c) <= $signed(d)) && ($signed(c) > $signed(u));
    return ($signed(c) <= $signed(d)) || ($signed(c) > $signed(u));
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (last_used_o == '0 && last_done_o == '0 && !new_valid_o));

  // R3
  wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (submit_i && !pause_i) |=>
      last_used_o == (($past(last_used_o) == TOP) ? 1 : $past(last_used_o) + 1));

  // R2
  issued_match_chk: assert property (@(posedge clk) disable iff (rst)
    (new_valid_o && !submit_err_o) |-> (new_cookie_o == last_used_o && $signed(new_cookie_o) > 0));

  // R4
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (submit_i && pause_i) |=> (submit_err_o && new_valid_o && $stable(last_used_o)));

  // R5
  done_order_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |-> ($signed(done_cookie_i) > 0 && !retired(done_cookie_i, last_done_o, last_used_o)));

  // R5
  done_take_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> last_done_o == $past(done_cookie_i));

  // R9
  held_only_paused_chk: assert property (@(posedge clk) disable iff (rst)
    (query_status_o == 2'd2) |-> pause_i);
endmodule

bind cookie_tracker cookie_tracker_chk #(.COOKIE_W(COOKIE_W)) chk_i (
  .clk(clk), .rst(rst), .submit_i(submit_i), .pause_i(pause_i), .done_i(done_i),
  .done_cookie_i(done_cookie_i), .new_cookie_o(new_cookie_o), .new_valid_o(new_valid_o),
  .submit_err_o(submit_err_o), .query_status_o(query_status_o),
  .last_done_o(last_done_o), .last_used_o(last_used_o)
);

// File: tb/cookie_tracker_tb_top.sv
`timescale 1ns/1ps
module cookie_tracker_tb_top;
  localparam int W    = 4;
  localparam int CMAX = (1 << (W-1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic submit_i = 0, pause_i = 0, done_i = 0, done_err_i = 0;
  logic [W-1:0] done_cookie_i = '0, query_cookie_i = '0;
  logic [W-1:0] new_cookie_o, last_done_o, last_used_o;
  logic new_valid_o, submit_err_o;
  logic [1:0] query_status_o;

  always #2 clk = ~clk;

  cookie_tracker #(.COOKIE_W(W)) dut_i (
    .clk(clk), .rst(rst), .submit_i(submit_i), .pause_i(pause_i), .done_i(done_i),
    .done_cookie_i(done_cookie_i), .done_err_i(done_err_i), .query_cookie_i(query_cookie_i),
    .new_cookie_o(new_cookie_o), .new_valid_o(new_valid_o), .submit_err_o(submit_err_o),
    .query_status_o(query_status_o), .last_done_o(last_done_o), .last_used_o(last_used_o)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  int mu = 0, md = 0, errc = 0, n_out = 0;
  bit errv = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return $signed(v);
  endfunction

  function automatic int adv(input int x);
    return (x == CMAX) ? 1 : x + 1;
  endfunction

  function automatic int exp_stat(input int q, input bit pz);
    bit c;
    if (md <= mu) c = (q <= md) || (q > mu);
    else          c = (q <= md) && (q > mu);
    if (c) return (errv && q == errc) ? 3 : 0;
    return pz ? 2 : 1;
  endfunction

  task automatic sweep_queries();
    for (int p = 0; p < 2; p++) begin
      pause_i = p[0];
      for (int q = 0; q < (1 << W); q++) begin
        query_cookie_i = q[W-1:0];
        #0.05;
        // R6 R7 R8 R9 R10
        chk((md > mu) ? "R8 wrapped status" : (p != 0 ? "R9 paused status" : "R7 status"),
            int'(query_status_o), exp_stat(sx(q[W-1:0]), p[0]));
      end
    end
  endtask

  task automatic cycle(input bit sub, input bit pz, input bit dn, input int dc, input bit de);
    int exp_c;
    int prev_mu;
    @(negedge clk);
    submit_i = sub; pause_i = pz; done_i = dn; done_cookie_i = dc[W-1:0]; done_err_i = de;
    @(posedge clk);
    #1;
    prev_mu = mu;
    exp_c = -1;
    if (sub && !pz) begin
      mu = adv(mu);
      exp_c = mu;
      n_out++;
    end
    if (dn) begin
      md = dc;
      if (de) begin errc = dc; errv = 1; end
    end
    if (sub && !pz && errv && errc == mu && !(dn && de)) errv = 0;
    submit_i = 0; done_i = 0; done_err_i = 0;
    chk("R2 new_valid", int'(new_valid_o), int'(sub));
    if (sub) begin
      if (pz) begin
        chk("R4 refused cookie", sx(new_cookie_o), -1);
        chk("R4 submit_err", int'(submit_err_o), 1);
      end else begin
        if (prev_mu == 0) chk("R1 first cookie", sx(new_cookie_o), 1);
        else if (prev_mu == CMAX) chk("R3 wrap cookie", sx(new_cookie_o), 1);
        else chk("R2 new cookie", sx(new_cookie_o), exp_c);
        chk("R4 submit_err low", int'(submit_err_o), 0);
      end
    end
    chk((sub && dn) ? "R11 last_used" : "R2 last_used", sx(last_used_o), mu);
    chk((sub && dn) ? "R11 last_done" : "R5 last_done", sx(last_done_o), md);
    sweep_queries();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #0.5;
    chk("R1 reset last_used", sx(last_used_o), 0);
    chk("R1 reset last_done", sx(last_done_o), 0);
    chk("R1 reset new_valid", int'(new_valid_o), 0);
    sweep_queries();
    // directed: first submit, refusal, simultaneous submit and completion
    cycle(1, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0);
    cycle(1, 0, 1, 1, 1);
    n_out--;
    for (int i = 0; i < 700; i++) begin
      bit sub, pz, dn, de;
      int k, dc;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sub = lf[0] | lf[5];
      pz  = (lf[3:1] == 3'b000);
      sub = sub && (n_out < CMAX - 1 || pz);
      dn  = lf[7] && (n_out > 0);
      de  = lf[9] & lf[8];
      dc  = md;
      if (dn) begin
        k = (lf[11] && n_out > 1) ? 2 : 1;
        for (int j = 0; j < k; j++) dc = adv(dc);
        n_out -= k;
      end
      cycle(sub, pz, dn, dc, de);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule